// File: doc/BRIEF.md
# Bridge Forwarding Window Decoder

This block decides whether a transaction seen on the upstream side of a PCI-to-PCI bridge falls inside one of the bridge's forwarding windows. The block is given the packed configuration fields of the bridge:

- the IO base and limit bytes, with their 16-bit upper extensions;
- the non-prefetchable memory base and limit words;
- the prefetchable base and limit words, with their 32-bit upper extensions;
- the IO and memory enable bits from the command register;
- the legacy display (VGA) forwarding enable.

From these fields it rebuilds the inclusive address bounds of each window. The granular fields are expanded into full addresses. A type bit in a field widens the address it gives. A limit has its low bits filled with ones.

Each cycle a request can be presented. A request is an address plus a flag that says whether it targets IO space or memory space. One cycle later the block reports a registered hit flag and a one-hot vector that names the window that matched. The surrounding logic uses these outputs to decide whether to claim the transaction and pass it downstream. Configuration storage and routing lie outside this block.

Top module: `bridge_window_decode`

## Requirements
- R1: IO base address: bits 15:12 come from bits 7:4 of the IO base byte, and bits 11:0 are zero. When bit 0 of that byte is 1 (32-bit IO), the IO base upper register supplies bits 31:16. Otherwise bits 31:16 are zero.
- R2: IO limit address: built the same way from the IO limit byte and its upper register. Bits 11:0 are then forced to ones.
- R3: Non-prefetchable memory window: bits 15:4 of the base or limit word become address bits 31:20, and bits 3:0 of the word are ignored. The limit has bits 19:0 forced to ones. Address bits 63:32 of both bounds are zero.
- R4: Prefetchable window: uses the same word layout as R3. When bit 0 of the base word (or of the limit word) is 1, the matching upper register supplies bits 63:32 of that bound. Otherwise bits 63:32 of that bound are zero.
- R5: The command IO enable gates the IO window. The command memory enable gates both memory windows.
- R6: A window whose limit is below its base is empty and never matches.
- R7: When the VGA enable is 1, the following ranges match whatever the command enables and the base/limit windows hold:
  - IO 0x3B0 to 0x3BB;
  - IO 0x3C0 to 0x3DF;
  - memory 0xA0000 to 0xBFFFF.
- R8: A match means base <= address <= limit, with both bounds inclusive.
  - An IO request (req_is_io=1) is compared only with the IO-space windows, using address bits 31:0; bits 63:32 are ignored.
  - A memory request is compared only with the memory-space windows, using all 64 bits.
- R9: The outputs update on the clock edge after a request. hit_o is 1 exactly when win_sel_o has one bit set. When req_valid is 0, both outputs become 0 on the next edge. Reset clears both outputs.
- R10: win_sel_o bit positions are: 0 VGA memory, 1 VGA IO low, 2 VGA IO high, 3 prefetchable, 4 non-prefetchable memory, 5 IO window. When several windows match, the lowest bit position wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_is_io | input | 1 | 1 = IO space request, 0 = memory space request |
| req_addr | input | 64 | Request address |
| cmd_io_en | input | 1 | Command register IO enable |
| cmd_mem_en | input | 1 | Command register memory enable |
| vga_en | input | 1 | Bridge control legacy display forwarding enable |
| io_base_b | input | 8 | IO base byte |
| io_limit_b | input | 8 | IO limit byte |
| io_base_hi | input | 16 | IO base upper 16 bits |
| io_limit_hi | input | 16 | IO limit upper 16 bits |
| mem_base_w | input | 16 | Non-prefetchable memory base word |
| mem_limit_w | input | 16 | Non-prefetchable memory limit word |
| pf_base_w | input | 16 | Prefetchable base word |
| pf_limit_w | input | 16 | Prefetchable limit word |
| pf_base_hi | input | 32 | Prefetchable base upper 32 bits |
| pf_limit_hi | input | 32 | Prefetchable limit upper 32 bits |
| hit_o | output | 1 | Registered forward decision |
| win_sel_o | output | 6 | Registered one-hot matching window |

## Verification
Fixed configuration, address table: with every window configured and enabled, a table of addresses is driven. It includes each bound, the address one past each limit and one below each base, and addresses that would match a window of the other space. These show whether each bound is inclusive and whether the IO and memory spaces stay separate.

Widths and type bits: further runs switch the IO and prefetchable type bits. They also put nonzero bits into the upper half of an IO address. This tells a 16-bit bound from a 32-bit one, and a 32-bit bound from a 64-bit one.

Enables and overlaps: directed runs clear each enable in turn and set up an inverted window. They also overlap the VGA memory range with the memory windows, which shows the enable gating, the empty-window rule and the selection priority apart.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  localparam int ADDR_W     = 64;
  localparam int IO_W       = 32;
  localparam int IO_GRAN    = 12;
  localparam int MEM_GRAN   = 20;
  localparam int NWIN       = 6;

  // window slots, lowest index has highest priority
  localparam int SLOT_VGA_MEM = 0;
  localparam int SLOT_VGA_LO  = 1;
  localparam int SLOT_VGA_HI  = 2;
  localparam int SLOT_PREF    = 3;
  localparam int SLOT_MEM     = 4;
  localparam int SLOT_IO      = 5;

  localparam logic [ADDR_W-1:0] VGA_LO_FIRST  = 64'h3B0;
  localparam logic [ADDR_W-1:0] VGA_LO_LAST   = 64'h3BB;
  localparam logic [ADDR_W-1:0] VGA_HI_FIRST  = 64'h3C0;
  localparam logic [ADDR_W-1:0] VGA_HI_LAST   = 64'h3DF;
  localparam logic [ADDR_W-1:0] VGA_MEM_FIRST = 64'hA0000;
  localparam logic [ADDR_W-1:0] VGA_MEM_LAST  = 64'hBFFFF;

  // IO bound from an 8-bit field plus 16-bit extension
  function automatic logic [ADDR_W-1:0] io_bound(input logic [7:0] fld,
                                                 input logic [15:0] ext,
                                                 input logic is_limit);
    logic [ADDR_W-1:0] v;
    v = '0;
    v[15:12] = fld[7:4];
    if (fld[0]) v[31:16] = ext;
    if (is_limit) v[IO_GRAN-1:0] = '1;
    return v;
  endfunction

  // memory bound from a 16-bit field; optional 32-bit extension
  function automatic logic [ADDR_W-1:0] mem_bound(input logic [15:0] fld,
                                                  input logic [31:0] ext,
                                                  input logic use_ext,
                                                  input logic is_limit);
    logic [ADDR_W-1:0] v;
    v = '0;
    v[31:20] = fld[15:4];
    if (use_ext && fld[0]) v[63:32] = ext;
    if (is_limit) v[MEM_GRAN-1:0] = '1;
    return v;
  endfunction
endpackage

// File: rtl/bwd_window_bounds.sv
module bwd_window_bounds
  import bwd_pkg::*;
(
  input  logic [7:0]  io_base_b,
  input  logic [7:0]  io_limit_b,
  input  logic [15:0] io_base_hi,
  input  logic [15:0] io_limit_hi,
  input  logic [15:0] mem_base_w,
  input  logic [15:0] mem_limit_w,
  input  logic [15:0] pf_base_w,
  input  logic [15:0] pf_limit_w,
  input  logic [31:0] pf_base_hi,
  input  logic [31:0] pf_limit_hi,
  input  logic        cmd_io_en,
  input  logic        cmd_mem_en,
  input  logic        vga_en,
  output logic [ADDR_W-1:0] lo [NWIN],
  output logic [ADDR_W-1:0] hi [NWIN],
  output logic [NWIN-1:0]   en,
  output logic [NWIN-1:0]   in_io_space
);
  always_comb begin
    lo[SLOT_VGA_MEM] = VGA_MEM_FIRST;
    hi[SLOT_VGA_MEM] = VGA_MEM_LAST;
    lo[SLOT_VGA_LO]  = VGA_LO_FIRST;
    hi[SLOT_VGA_LO]  = VGA_LO_LAST;
    lo[SLOT_VGA_HI]  = VGA_HI_FIRST;
    hi[SLOT_VGA_HI]  = VGA_HI_LAST;
    lo[SLOT_PREF]    = mem_bound(pf_base_w,  pf_base_hi,  1'b1, 1'b0);
    hi[SLOT_PREF]    = mem_bound(pf_limit_w, pf_limit_hi, 1'b1, 1'b1);
    lo[SLOT_MEM]     = mem_bound(mem_base_w,  32'h0, 1'b0, 1'b0);
    hi[SLOT_MEM]     = mem_bound(mem_limit_w, 32'h0, 1'b0, 1'b1);
    lo[SLOT_IO]      = io_bound(io_base_b,  io_base_hi,  1'b0);
    hi[SLOT_IO]      = io_bound(io_limit_b, io_limit_hi, 1'b1);

    en = '0;
    en[SLOT_VGA_MEM] = vga_en;
    en[SLOT_VGA_LO]  = vga_en;
    en[SLOT_VGA_HI]  = vga_en;
    en[SLOT_PREF]    = cmd_mem_en;
    en[SLOT_MEM]     = cmd_mem_en;
    en[SLOT_IO]      = cmd_io_en;

    in_io_space = '0;
    in_io_space[SLOT_VGA_LO] = 1'b1;
    in_io_space[SLOT_VGA_HI] = 1'b1;
    in_io_space[SLOT_IO]     = 1'b1;
  end
endmodule

// File: rtl/bwd_range_cmp.sv
module bwd_range_cmp #(
  parameter int W = 64
) (
  input  logic         en,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  input  logic [W-1:0] addr,
  output logic         hit
);
  logic non_empty;
  assign non_empty = (lo <= hi);
  assign hit = en && non_empty && (addr >= lo) && (addr <= hi);
endmodule

// File: rtl/bwd_onehot_pick.sv
module bwd_onehot_pick #(
  parameter int N = 6
) (
  input  logic [N-1:0] raw,
  output logic [N-1:0] pick
);
  // isolate lowest set bit
  assign pick = raw & (~raw + N'(1));
endmodule

// File: rtl/bridge_window_decode.sv
module bridge_window_decode
  import bwd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_is_io,
  input  logic [63:0]       req_addr,
  input  logic              cmd_io_en,
  input  logic              cmd_mem_en,
  input  logic              vga_en,
  input  logic [7:0]        io_base_b,
  input  logic [7:0]        io_limit_b,
  input  logic [15:0]       io_base_hi,
  input  logic [15:0]       io_limit_hi,
  input  logic [15:0]       mem_base_w,
  input  logic [15:0]       mem_limit_w,
  input  logic [15:0]       pf_base_w,
  input  logic [15:0]       pf_limit_w,
  input  logic [31:0]       pf_base_hi,
  input  logic [31:0]       pf_limit_hi,
  output logic              hit_o,
  output logic [5:0]        win_sel_o
);
  logic [ADDR_W-1:0] lo [NWIN];
  logic [ADDR_W-1:0] hi [NWIN];
  logic [NWIN-1:0]   en;
  logic [NWIN-1:0]   in_io_space;
  logic [ADDR_W-1:0] io_addr;
  logic [NWIN-1:0]   raw_match;
  logic [NWIN-1:0]   pick;

  bwd_window_bounds u_bounds (
    .io_base_b   (io_base_b),
    .io_limit_b  (io_limit_b),
    .io_base_hi  (io_base_hi),
    .io_limit_hi (io_limit_hi),
    .mem_base_w  (mem_base_w),
    .mem_limit_w (mem_limit_w),
    .pf_base_w   (pf_base_w),
    .pf_limit_w  (pf_limit_w),
    .pf_base_hi  (pf_base_hi),
    .pf_limit_hi (pf_limit_hi),
    .cmd_io_en   (cmd_io_en),
    .cmd_mem_en  (cmd_mem_en),
    .vga_en      (vga_en),
    .lo          (lo),
    .hi          (hi),
    .en          (en),
    .in_io_space (in_io_space)
  );

  // IO space sees only the low address bits
  assign io_addr = {{(ADDR_W-IO_W){1'b0}}, req_addr[IO_W-1:0]};

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    logic space_ok;
    logic [ADDR_W-1:0] cmp_addr;
    assign space_ok = (in_io_space[g] == req_is_io);
    assign cmp_addr = in_io_space[g] ? io_addr : req_addr;
    bwd_range_cmp #(.W(ADDR_W)) u_cmp (
      .en   (en[g] && space_ok),
      .lo   (lo[g]),
      .hi   (hi[g]),
      .addr (cmp_addr),
      .hit  (raw_match[g])
    );
  end

  bwd_onehot_pick #(.N(NWIN)) u_pick (
    .raw  (raw_match),
    .pick (pick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_o     <= 1'b0;
      win_sel_o <= '0;
    end else if (req_valid) begin
      hit_o     <= |pick;
      win_sel_o <= pick;
    end else begin
      hit_o     <= 1'b0;
      win_sel_o <= '0;
    end
  end
endmodule

// File: rtl/bwd_checker.sv
module bwd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_is_io,
  input logic       cmd_io_en,
  input logic       cmd_mem_en,
  input logic       vga_en,
  input logic [5:0] raw_match,
  input logic       hit_o,
  input logic [5:0] win_sel_o
);
  assert_sel_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_sel_o) && (hit_o == (win_sel_o != 6'd0)));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!hit_o && win_sel_o == 6'd0));

  assert_hit_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (hit_o == $past(raw_match != 6'd0)));

  assert_io_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_is_io && !cmd_io_en) |=> !win_sel_o[5]);

  assert_mem_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_is_io && !cmd_mem_en) |=> (win_sel_o[4:3] == 2'b00));

  assert_vga_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !vga_en) |=> (win_sel_o[2:0] == 3'b000));

  assert_space_split_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_is_io) |=> (!win_sel_o[0] && !win_sel_o[3] && !win_sel_o[4]));

  assert_space_split_mem_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_is_io) |=> (!win_sel_o[1] && !win_sel_o[2] && !win_sel_o[5]));

  assert_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && raw_match[0]) |=> win_sel_o[0]);
endmodule

bind bridge_window_decode bwd_checker u_bwd_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_is_io  (req_is_io),
  .cmd_io_en  (cmd_io_en),
  .cmd_mem_en (cmd_mem_en),
  .vga_en     (vga_en),
  .raw_match  (raw_match),
  .hit_o      (hit_o),
  .win_sel_o  (win_sel_o)
);

// File: tb/tb_bridge_window_decode.sv
`timescale 1ns/1ps
module tb_bridge_window_decode;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_is_io = 1'b0;
  logic [63:0] req_addr = '0;
  logic        cmd_io_en, cmd_mem_en, vga_en;
  logic [7:0]  io_base_b, io_limit_b;
  logic [15:0] io_base_hi, io_limit_hi;
  logic [15:0] mem_base_w, mem_limit_w, pf_base_w, pf_limit_w;
  logic [31:0] pf_base_hi, pf_limit_hi;
  logic        hit_o;
  logic [5:0]  win_sel_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  bridge_window_decode dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_io(req_is_io),
    .req_addr(req_addr), .cmd_io_en(cmd_io_en), .cmd_mem_en(cmd_mem_en),
    .vga_en(vga_en), .io_base_b(io_base_b), .io_limit_b(io_limit_b),
    .io_base_hi(io_base_hi), .io_limit_hi(io_limit_hi),
    .mem_base_w(mem_base_w), .mem_limit_w(mem_limit_w),
    .pf_base_w(pf_base_w), .pf_limit_w(pf_limit_w),
    .pf_base_hi(pf_base_hi), .pf_limit_hi(pf_limit_hi),
    .hit_o(hit_o), .win_sel_o(win_sel_o)
  );

  // select bits: 0 VGA mem, 1 VGA IO lo, 2 VGA IO hi, 3 pref, 4 mem, 5 IO
  typedef struct packed {
    logic        io;
    logic [63:0] addr;
    logic [5:0]  sel;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 64'h0000_0000_0001_2000, 6'b100000},  // R1 IO base edge
    '{1'b1, 64'h0000_0000_0001_3FFF, 6'b100000},  // R2 IO limit edge
    '{1'b1, 64'h0000_0000_0001_4000, 6'b000000},  // R2 past limit
    '{1'b1, 64'h0000_0000_0001_1FFF, 6'b000000},  // R1 below base
    '{1'b1, 64'h0000_0000_0000_03B0, 6'b000010},  // R7
    '{1'b1, 64'h0000_0000_0000_03BB, 6'b000010},  // R7
    '{1'b1, 64'h0000_0000_0000_03BC, 6'b000000},  // R7
    '{1'b1, 64'h0000_0000_0000_03C0, 6'b000100},  // R7
    '{1'b1, 64'h0000_0000_0000_03DF, 6'b000100},  // R7
    '{1'b1, 64'h0000_0000_0000_03E0, 6'b000000},  // R7
    '{1'b0, 64'h0000_0000_000A_0000, 6'b000001},  // R7
    '{1'b0, 64'h0000_0000_000B_FFFF, 6'b000001},  // R7
    '{1'b0, 64'h0000_0000_000C_0000, 6'b000000},  // R7
    '{1'b0, 64'h0000_0000_8000_0000, 6'b010000},  // R3
    '{1'b0, 64'h0000_0000_80FF_FFFF, 6'b010000},  // R3
    '{1'b0, 64'h0000_0000_8100_0000, 6'b000000},  // R3
    '{1'b0, 64'h0000_0001_C000_0000, 6'b001000},  // R4
    '{1'b0, 64'h0000_0001_C01F_FFFF, 6'b001000},  // R4
    '{1'b0, 64'h0000_0000_C000_0000, 6'b000000},  // R4 upper differs
    '{1'b1, 64'h0000_0000_8000_0000, 6'b000000},  // R8 IO vs mem window
    '{1'b0, 64'h0000_0000_0001_2000, 6'b000000},  // R8 mem vs IO window
    '{1'b0, 64'h0000_0000_0000_03B0, 6'b000000},  // R8 mem vs VGA IO
    '{1'b1, 64'hFFFF_FFFF_0001_2000, 6'b100000}   // R8 IO upper bits ignored
  };

  task automatic base_cfg();
    cmd_io_en = 1'b1; cmd_mem_en = 1'b1; vga_en = 1'b1;
    io_base_b = 8'h21;  io_base_hi = 16'h0001;
    io_limit_b = 8'h31; io_limit_hi = 16'h0001;
    mem_base_w = 16'h800F; mem_limit_w = 16'h80F0;
    pf_base_w = 16'hC001;  pf_base_hi = 32'h1;
    pf_limit_w = 16'hC011; pf_limit_hi = 32'h1;
  endtask

  task automatic check(input string tag, input logic [5:0] exp);
    checks++;
    if (hit_o !== (exp != 6'd0) || win_sel_o !== exp) begin
      fails++;
      $display("FAIL %s: hit=%0b sel=%b expected hit=%0b sel=%b",
               tag, hit_o, win_sel_o, (exp != 6'd0), exp);
    end
  endtask

  // drive at negedge, outputs register at the next posedge, sample at negedge after
  task automatic apply(input string tag, input logic io, input logic [63:0] a,
                       input logic [5:0] exp);
    @(negedge clk);
    req_valid = 1'b1; req_is_io = io; req_addr = a;
    @(negedge clk);
    check(tag, exp);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    check(tag, 6'b000000);
  endtask

  initial begin
    base_cfg();
    repeat (3) @(negedge clk);
    check("R9 reset state", 6'b000000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply($sformatf("R8 table entry %0d", i), TBL[i].io, TBL[i].addr, TBL[i].sel);
    end

    idle("R9 idle after request");

    // R1 16-bit IO: extension ignored
    io_base_b = 8'h20; io_limit_b = 8'h30;
    apply("R1 16-bit IO base", 1'b1, 64'h2000, 6'b100000);
    apply("R2 16-bit IO limit", 1'b1, 64'h3FFF, 6'b100000);
    apply("R1 16-bit IO ext ignored", 1'b1, 64'h0001_2000, 6'b000000);
    base_cfg();

    // R6 inverted window
    mem_base_w = 16'h9000; mem_limit_w = 16'h8000;
    apply("R6 empty window low", 1'b0, 64'h8800_0000, 6'b000000);
    apply("R6 empty window base", 1'b0, 64'h9000_0000, 6'b000000);
    base_cfg();

    // R5 memory enable off, VGA still forwards
    cmd_mem_en = 1'b0;
    apply("R5 mem disabled", 1'b0, 64'h8000_0000, 6'b000000);
    apply("R5 pref disabled", 1'b0, 64'h1_C000_0000, 6'b000000);
    apply("R7 VGA mem without mem enable", 1'b0, 64'hA0000, 6'b000001);
    base_cfg();

    cmd_io_en = 1'b0;
    apply("R5 IO disabled", 1'b1, 64'h0001_2000, 6'b000000);
    apply("R7 VGA IO without IO enable", 1'b1, 64'h3B0, 6'b000010);
    base_cfg();

    vga_en = 1'b0;
    apply("R7 VGA off IO", 1'b1, 64'h3C0, 6'b000000);
    apply("R7 VGA off mem", 1'b0, 64'hA0000, 6'b000000);
    base_cfg();

    // R4 32-bit prefetchable: extension ignored
    pf_base_w = 16'hC000; pf_limit_w = 16'hC010;
    apply("R4 32-bit pref base", 1'b0, 64'hC000_0000, 6'b001000);
    apply("R4 32-bit pref limit", 1'b0, 64'hC01F_FFFF, 6'b001000);
    apply("R4 32-bit pref ext ignored", 1'b0, 64'h1_C000_0000, 6'b000000);
    base_cfg();

    // R10 priority with overlapping windows
    mem_base_w = 16'h0000; mem_limit_w = 16'h0000;
    apply("R10 VGA over mem", 1'b0, 64'hA0000, 6'b000001);
    apply("R3 zero-based mem window", 1'b0, 64'hFFFFF, 6'b010000);
    pf_base_w = 16'h0000; pf_limit_w = 16'h0000;
    apply("R10 pref over mem", 1'b0, 64'h5_0000, 6'b001000);
    vga_en = 1'b0;
    apply("R10 pref over mem VGA off", 1'b0, 64'hA0000, 6'b001000);
    base_cfg();

    // R9 reset clears a pending hit
    apply("R9 hit before reset", 1'b0, 64'h8000_0000, 6'b010000);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 reset clears", 6'b000000);
    rst_n = 1'b1;
    req_valid = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule